// File: doc/BRIEF.md
# Segmented Memory Address Generator

This block turns an 8-bit offset into the 16-bit physical address for every memory access of a small 8-bit processor. It holds four 8-bit segment registers (code, data, extra and stack) and the 8-bit stack pointer. The caller states the kind of access each cycle: an instruction fetch, a normal data access or a single-byte stack push or pop. It can also set a bit that selects the extra segment. The block then drives the address of the byte and the address of the byte after it, so the caller can move 16 bits to two consecutive locations.

The block also runs the two-cycle extended push and pop of a segment/register pair. It supplies the byte to be stored at each step and loads the popped segment byte back into its segment register. A far-pointer load port takes a 16-bit word read from memory. The byte at the lower address becomes the new code segment, and the byte at the higher address is handed back as the new instruction pointer.

Top module: `segaddr_gen`

## Requirements
- R1: While reset is active and in the first cycle after it, all four segment registers and the stack pointer are zero, `busy` is 0 and `memEn` is 0 when `accClass` is 0.
- R2: With `accClass` = 1 (fetch), `memAddr` = {code segment, `offset`}, whatever the value of `useExtra`.
- R3: With `accClass` = 2 (data), `memAddr` = {data segment, `offset`}, or {extra segment, `offset`} when `useExtra` is 1.
- R4: With `accClass` = 3 (stack), the segment is the stack segment, or the extra segment when `useExtra` is 1. A push (`stackPush` = 1) addresses stack pointer − 1, raises `stackWr` and leaves the pointer decremented. A pop addresses the stack pointer and leaves it incremented. All pointer arithmetic wraps modulo 256.
- R5: Whenever `memEn` is 1, `memAddr2` has the same upper byte as `memAddr`, and its lower byte is the lower byte of `memAddr` plus 1, wrapping modulo 256.
- R6: A segment write (`segWrEn`, with `segWrSel` 0 = code, 1 = data, 2 = extra, 3 = stack) takes effect on the next clock edge. A stack-pointer write (`spWrEn`) also takes effect on the next edge when no stack access happens in that cycle.
- R7: `farLoad` loads `farWord[15:8]` (the byte at the lower address) into the code segment on the next edge. In the same cycle it drives `ipLoadEn` = 1 and `ipLoadVal` = `farWord[7:0]`.
- R8: `xPush` runs two cycles. In the first, `segStep` = 1 and the segment selected by `pairSel` is driven on `pushByte` at stack pointer − 1. In the second, `busy` = 1, `segStep` = 0, and `regData` is driven at stack pointer − 2. The pointer ends 2 lower.
- R9: `xPop` runs two cycles. In the first, `segStep` = 0 and the register byte is read at the stack pointer. In the second, `busy` = 1 and `segStep` = 1, the address is stack pointer + 1, and `popByte` is loaded into the segment selected by `pairSel`. The pointer ends 2 higher.
- R10: While `busy` is 1, `accClass`, `xPush`, `xPop`, `useExtra` and `pairSel` are ignored.
- R11: With no request (`accClass` = 0 and neither `xPush` nor `xPop`) and `busy` = 0, `memEn` is 0 and `memAddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accClass | input | 2 | 0 none, 1 fetch, 2 data, 3 stack |
| useExtra | input | 1 | Select the extra segment for data and stack accesses |
| stackPush | input | 1 | For a stack access: 1 push, 0 pop |
| offset | input | 8 | Offset for fetch and data accesses |
| segWrEn | input | 1 | Segment register write enable |
| segWrSel | input | 2 | Segment register to write |
| segWrData | input | 8 | Segment write value |
| spWrEn | input | 1 | Stack pointer write enable |
| spWrData | input | 8 | Stack pointer write value |
| farLoad | input | 1 | Far-pointer load strobe |
| farWord | input | 16 | Far pointer as read, lower-address byte in [15:8] |
| xPush | input | 1 | Start extended push of a segment/register pair |
| xPop | input | 1 | Start extended pop of a segment/register pair |
| pairSel | input | 2 | Segment of the pair, same encoding as segWrSel |
| regData | input | 8 | Register byte to push in the second push step |
| popByte | input | 8 | Byte read from memory in the second pop step |
| memAddr | output | 16 | Address of the byte accessed |
| memAddr2 | output | 16 | Address of the next byte in the same segment |
| memEn | output | 1 | An access happens this cycle |
| stackAcc | output | 1 | The access is a stack access |
| stackWr | output | 1 | The stack access is a push |
| segStep | output | 1 | The current pair step moves the segment byte |
| pushByte | output | 8 | Byte to store on a pair push step |
| busy | output | 1 | Second step of an extended push or pop |
| stackPtr | output | 8 | Current stack pointer |
| ipLoadEn | output | 1 | New instruction pointer valid |
| ipLoadVal | output | 8 | New instruction pointer |

## Verification
The assertions assume that a stack-pointer write never coincides with a stack access. They read the pointer that follows a push or a pop directly from the address driven in that cycle. They also assume that `accClass` is used only with `xPush` and `xPop` low, because the extended operations take priority over it. The stimulus never asserts `spWrEn` in a stack cycle. It raises `accClass` alongside `xPush` and `xPop` only during the busy second step, where R10 requires it to be ignored.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;
  localparam int SEG_W = 8;
  localparam int OFF_W = 8;
  localparam int SEG_N = 4;
  localparam int SEL_W = $clog2(SEG_N);

  typedef enum logic [1:0] {ACC_NONE, ACC_FETCH, ACC_DATA, ACC_STACK} accClass_e;
  typedef enum logic [1:0] {SEG_CODE, SEG_DATA, SEG_EXTRA, SEG_STACK} segSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             accEn;
    logic             selCode;
    logic             selStack;
    logic             useExtra;
    logic             spDec;
    logic             spInc;
    logic             byteFromSeg;
    logic             loadPopSeg;
    logic             stepSeg;
    logic [SEL_W-1:0] pairSegSel;
  } strobes_t;
endpackage

// File: rtl/segaddr_ctrl.sv
module segaddr_ctrl
  import segaddr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       accClass,
  input  logic             useExtra,
  input  logic             stackPush,
  input  logic             xPush,
  input  logic             xPop,
  input  logic [SEL_W-1:0] pairSel,
  output strobes_t         st,
  output logic             busy
);
  typedef enum logic [1:0] {S_IDLE, S_PUSH2, S_POP2} state_e;

  state_e           state, stateNext;
  logic [SEL_W-1:0] pairSelQ;
  logic             extraQ;

  always_comb begin
    st        = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (xPush) begin
          st.accEn       = 1'b1;
          st.selStack    = 1'b1;
          st.useExtra    = useExtra;
          st.spDec       = 1'b1;
          st.byteFromSeg = 1'b1;
          st.stepSeg     = 1'b1;
          st.pairSegSel  = pairSel;
          stateNext      = S_PUSH2;
        end else if (xPop) begin
          st.accEn    = 1'b1;
          st.selStack = 1'b1;
          st.useExtra = useExtra;
          st.spInc    = 1'b1;
          stateNext   = S_POP2;
        end else begin
          unique case (accClass_e'(accClass))
            ACC_FETCH: begin
              st.accEn   = 1'b1;
              st.selCode = 1'b1;
            end
            ACC_DATA: begin
              st.accEn    = 1'b1;
              st.useExtra = useExtra;
            end
            ACC_STACK: begin
              st.accEn    = 1'b1;
              st.selStack = 1'b1;
              st.useExtra = useExtra;
              st.spDec    = stackPush;
              st.spInc    = !stackPush;
            end
            default: ;
          endcase
        end
      end
      S_PUSH2: begin
        st.accEn    = 1'b1;
        st.selStack = 1'b1;
        st.useExtra = extraQ;
        st.spDec    = 1'b1;
        stateNext   = S_IDLE;
      end
      S_POP2: begin
        st.accEn      = 1'b1;
        st.selStack   = 1'b1;
        st.useExtra   = extraQ;
        st.spInc      = 1'b1;
        st.stepSeg    = 1'b1;
        st.loadPopSeg = 1'b1;
        st.pairSegSel = pairSelQ;
        stateNext     = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      pairSelQ <= '0;
      extraQ   <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE) begin
        pairSelQ <= pairSel;
        extraQ   <= useExtra;
      end
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/segaddr_dp.sv
module segaddr_dp
  import segaddr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               st,
  input  logic [OFF_W-1:0]       offset,
  input  logic                   segWrEn,
  input  logic [SEL_W-1:0]       segWrSel,
  input  logic [SEG_W-1:0]       segWrData,
  input  logic                   spWrEn,
  input  logic [OFF_W-1:0]       spWrData,
  input  logic                   farLoad,
  input  logic [SEG_W+OFF_W-1:0] farWord,
  input  logic [SEG_W-1:0]       regData,
  input  logic [SEG_W-1:0]       popByte,
  output logic [SEG_W+OFF_W-1:0] memAddr,
  output logic [SEG_W+OFF_W-1:0] memAddr2,
  output logic [SEG_W-1:0]       pushByte,
  output logic [OFF_W-1:0]       stackPtr
);
  localparam int ADDR_W = SEG_W + OFF_W;
  localparam logic [OFF_W-1:0] ONE = OFF_W'(1);

  logic [SEG_W-1:0] segRegs [SEG_N];
  logic [OFF_W-1:0] sp;
  logic [SEG_W-1:0] segCur;
  logic [OFF_W-1:0] lowCur;

  for (genvar g = 0; g < SEG_N; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rstN)
        segRegs[g] <= '0;
      else if (st.loadPopSeg && st.pairSegSel == SEL_W'(g))
        segRegs[g] <= popByte;
      else if (g == int'(SEG_CODE) && farLoad)
        segRegs[g] <= farWord[ADDR_W-1:OFF_W];
      else if (segWrEn && segWrSel == SEL_W'(g))
        segRegs[g] <= segWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          sp <= '0;
    else if (st.spDec)  sp <= sp - ONE;
    else if (st.spInc)  sp <= sp + ONE;
    else if (spWrEn)    sp <= spWrData;
  end

  always_comb begin
    if (st.selCode)       segCur = segRegs[SEG_CODE];
    else if (st.useExtra) segCur = segRegs[SEG_EXTRA];
    else if (st.selStack) segCur = segRegs[SEG_STACK];
    else                  segCur = segRegs[SEG_DATA];
    if (st.selStack) lowCur = st.spDec ? sp - ONE : sp;
    else             lowCur = offset;
  end

  assign memAddr  = st.accEn ? {segCur, lowCur} : '0;
  assign memAddr2 = st.accEn ? {segCur, lowCur + ONE} : '0;
  assign pushByte = st.byteFromSeg ? segRegs[st.pairSegSel] : regData;
  assign stackPtr = sp;
endmodule

// File: rtl/segaddr_gen.sv
module segaddr_gen
  import segaddr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  accClass,
  input  logic        useExtra,
  input  logic        stackPush,
  input  logic [7:0]  offset,
  input  logic        segWrEn,
  input  logic [1:0]  segWrSel,
  input  logic [7:0]  segWrData,
  input  logic        spWrEn,
  input  logic [7:0]  spWrData,
  input  logic        farLoad,
  input  logic [15:0] farWord,
  input  logic        xPush,
  input  logic        xPop,
  input  logic [1:0]  pairSel,
  input  logic [7:0]  regData,
  input  logic [7:0]  popByte,
  output logic [15:0] memAddr,
  output logic [15:0] memAddr2,
  output logic        memEn,
  output logic        stackAcc,
  output logic        stackWr,
  output logic        segStep,
  output logic [7:0]  pushByte,
  output logic        busy,
  output logic [7:0]  stackPtr,
  output logic        ipLoadEn,
  output logic [7:0]  ipLoadVal
);
  strobes_t st;

  segaddr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accClass(accClass), .useExtra(useExtra),
    .stackPush(stackPush), .xPush(xPush), .xPop(xPop), .pairSel(pairSel),
    .st(st), .busy(busy)
  );

  segaddr_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st), .offset(offset),
    .segWrEn(segWrEn), .segWrSel(segWrSel), .segWrData(segWrData),
    .spWrEn(spWrEn), .spWrData(spWrData), .farLoad(farLoad), .farWord(farWord),
    .regData(regData), .popByte(popByte), .memAddr(memAddr), .memAddr2(memAddr2),
    .pushByte(pushByte), .stackPtr(stackPtr)
  );

  assign memEn     = st.accEn;
  assign stackAcc  = st.selStack;
  assign stackWr   = st.selStack & st.spDec;
  assign segStep   = st.stepSeg;
  assign ipLoadEn  = farLoad;
  assign ipLoadVal = farWord[7:0];
endmodule

// File: rtl/segaddr_chk.sv
module segaddr_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  accClass,
  input logic [7:0]  offset,
  input logic        xPush,
  input logic        xPop,
  input logic [15:0] memAddr,
  input logic [15:0] memAddr2,
  input logic        memEn,
  input logic        stackAcc,
  input logic        stackWr,
  input logic        segStep,
  input logic        busy,
  input logic [7:0]  stackPtr
);
  // R2
  fetch_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accClass == 2'd1 && !busy && !xPush && !xPop) |-> memAddr[7:0] == offset);

  // R4
  push_sp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && stackAcc && stackWr) |=> stackPtr == $past(memAddr[7:0]));

  // R4
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && stackAcc && !stackWr) |=> stackPtr == $past(memAddr[7:0]) + 8'd1);

  // R5
  pair_seg_chk: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> (memAddr2[15:8] == memAddr[15:8] &&
               8'(memAddr2[7:0] - memAddr[7:0]) == 8'd1));

  // R8
  pair_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (stackAcc && memEn && segStep == !stackWr));

  // R10
  busy_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accClass == 2'd0 && !busy && !xPush && !xPop) |-> (!memEn && memAddr == 16'h0));
endmodule

bind segaddr_gen segaddr_chk u_chk (
  .clk(clk), .rstN(rstN), .accClass(accClass), .offset(offset),
  .xPush(xPush), .xPop(xPop), .memAddr(memAddr), .memAddr2(memAddr2),
  .memEn(memEn), .stackAcc(stackAcc), .stackWr(stackWr), .segStep(segStep),
  .busy(busy), .stackPtr(stackPtr)
);

// File: tb/segaddr_gen_bench.sv
module segaddr_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  accClass = '0;
  logic        useExtra = 1'b0, stackPush = 1'b0;
  logic [7:0]  offset = '0;
  logic        segWrEn = 1'b0;
  logic [1:0]  segWrSel = '0;
  logic [7:0]  segWrData = '0;
  logic        spWrEn = 1'b0;
  logic [7:0]  spWrData = '0;
  logic        farLoad = 1'b0;
  logic [15:0] farWord = '0;
  logic        xPush = 1'b0, xPop = 1'b0;
  logic [1:0]  pairSel = '0;
  logic [7:0]  regData = '0, popByte = '0;
  logic [15:0] memAddr, memAddr2;
  logic        memEn, stackAcc, stackWr, segStep, busy, ipLoadEn;
  logic [7:0]  pushByte, stackPtr, ipLoadVal;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;
  logic [7:0] segM [4];
  logic [7:0] spM;

  always #4 clk = ~clk;

  segaddr_gen u_segaddr_gen (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleIn();
    accClass = 2'd0; useExtra = 0; stackPush = 0; segWrEn = 0; spWrEn = 0;
    farLoad = 0; xPush = 0; xPop = 0;
  endtask

  task automatic writeSeg(input logic [1:0] sel, input logic [7:0] val);
    segWrEn = 1; segWrSel = sel; segWrData = val;
    @(negedge clk); segWrEn = 0; segM[sel] = val;
  endtask

  task automatic setSp(input logic [7:0] val);
    spWrEn = 1; spWrData = val;
    @(negedge clk); spWrEn = 0; spM = val;
  endtask

  task automatic stackOp(input bit push, input bit ext);
    logic [7:0] seg;
    seg = ext ? segM[2] : segM[3];
    accClass = 2'd3; stackPush = push; useExtra = ext;
    #2;
    chk("R4 stack addr", memAddr, {seg, push ? 8'(spM - 8'd1) : spM});
    chk("R4 stack dir", {stackAcc, stackWr}, {1'b1, push});
    @(negedge clk); idleIn();
    spM = push ? 8'(spM - 8'd1) : 8'(spM + 8'd1);
    #1 chk("R4 sp after", stackPtr, spM);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset busy", busy, 0);
    chk("R1 reset sp", stackPtr, 0);
    @(negedge clk); rstN = 1;
    for (int i = 0; i < 4; i++) segM[i] = 8'h00;
    spM = 8'h00;
    #2;
    chk("R1 idle memEn", memEn, 0);
    chk("R1 sp zero", stackPtr, 0);
    accClass = 2'd1; offset = 8'h5A; #1;
    chk("R1 code seg zero", memAddr, 16'h005A);
    accClass = 2'd2; useExtra = 1; #1;
    chk("R1 extra seg zero", memAddr, 16'h005A);
    idleIn();
    @(negedge clk);

    // R6 segment writes, distinct values
    for (int g = 0; g < 4; g++) writeSeg(2'(g), 8'(8'h13 + g * 8'h2F));

    // R2 R3 R5 sweep of every offset
    for (int o = 0; o < 256; o++) begin
      offset = 8'(o);
      accClass = 2'd1; useExtra = o[0]; #1;
      chk("R2 fetch", memAddr, {segM[0], 8'(o)});
      chk("R5 fetch pair", memAddr2, {segM[0], 8'(o + 1)});
      accClass = 2'd2; useExtra = 0; #1;
      chk("R3 data", memAddr, {segM[1], 8'(o)});
      useExtra = 1; #1;
      chk("R3 extra", memAddr, {segM[2], 8'(o)});
      chk("R5 extra pair", memAddr2, {segM[2], 8'(o + 1)});
      idleIn();
      @(negedge clk);
    end

    // R11 no request
    #2 chk("R11 idle", {memEn, memAddr}, 17'h0);
    @(negedge clk);

    // R4 stack wrap, both segments
    setSp(8'h02);
    chk("R6 sp write", stackPtr, 8'h02);
    for (int k = 0; k < 4; k++) stackOp(1'b1, k[0]);
    for (int k = 0; k < 4; k++) stackOp(1'b0, k[0]);

    // R6 rewrite one segment
    writeSeg(2'd3, 8'hC4);
    accClass = 2'd3; stackPush = 0; #2;
    chk("R6 stack seg", memAddr, {8'hC4, spM});
    idleIn();
    @(negedge clk);

    // R7 far pointer
    farLoad = 1; farWord = 16'hA55A; #2;
    chk("R7 ip load", {ipLoadEn, ipLoadVal}, {1'b1, 8'h5A});
    @(negedge clk); idleIn(); segM[0] = 8'hA5;
    accClass = 2'd1; offset = 8'h33; #2;
    chk("R7 code seg", memAddr, 16'hA533);
    idleIn();
    @(negedge clk);

    // R8 extended push of data segment
    setSp(8'h10);
    xPush = 1; pairSel = 2'd1; regData = 8'h77; #2;
    chk("R8 step1 addr", memAddr, {segM[3], 8'h0F});
    chk("R8 step1 byte", {segStep, stackWr, pushByte}, {1'b1, 1'b1, segM[1]});
    @(negedge clk);
    xPush = 0; xPop = 1; accClass = 2'd1; pairSel = 2'd0; useExtra = 1; #2;
    chk("R8 step2 addr", memAddr, {segM[3], 8'h0E});
    chk("R8 step2 byte", {busy, segStep, stackWr, pushByte}, {1'b1, 1'b0, 1'b1, 8'h77});
    @(negedge clk); idleIn(); #1;
    chk("R10 ignored while busy", {busy, stackPtr}, {1'b0, 8'h0E});
    @(negedge clk);

    // R9 extended pop into extra segment
    xPop = 1; pairSel = 2'd2; #2;
    chk("R9 step1", {segStep, stackWr, memAddr}, {1'b0, 1'b0, segM[3], 8'h0E});
    @(negedge clk);
    xPop = 0; xPush = 1; pairSel = 2'd0; popByte = 8'h3C; #2;
    chk("R9 step2", {busy, segStep, stackWr, memAddr}, {1'b1, 1'b1, 1'b0, segM[3], 8'h0F});
    @(negedge clk); idleIn(); segM[2] = 8'h3C;
    #1 chk("R9 sp", stackPtr, 8'h10);
    accClass = 2'd2; useExtra = 1; offset = 8'h01; #1;
    chk("R9 extra loaded", memAddr, 16'h3C01);
    accClass = 2'd1; #1;
    chk("R10 code untouched", memAddr, {segM[0], 8'h01});
    idleIn();
    @(negedge clk);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      nBad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule